// File: doc/BRIEF.md
# CAN Interrupt Identifier and Line Combiner

This block merges the interrupt sources of a CAN controller onto two interrupt lines and produces, for each line, a 16-bit identifier naming the most urgent pending source. Message-object interrupts arrive as a vector of pending flags, one per object, together with a routing vector that sends each object to line 0 or line 1. Status-change updates and error-state changes from the protocol core form one combined source. That source can only reach line 0, where it outranks every message object.

The block holds a small error/status register. The core loads it, software reads it through a read strobe, and a read clears the status fields together with the combined status/error interrupt. The identifiers follow the pending inputs combinationally and keep tracking them when both lines are disabled, so software can poll them. A small state machine tracks the combined source. It has two states, `SE_IDLE` (nothing to report) and `SE_PEND` (the core updated the register since the last read). Transition `SE_IDLE -> SE_PEND` is taken on an enabled status update or an enabled error event. Transition `SE_PEND -> SE_IDLE` is taken on a register read with no new enabled event in the same cycle.

Top module: `can_irq_ident`

## Requirements
- R1: After reset, and whenever no source is pending for a line, that line's identifier is 0 and its line output is low; after reset the error/status read value is 0.
- R2: While the combined status/error source is pending, the line-0 identifier is 0x8000, whatever message objects are pending.
- R3: Otherwise, each identifier is the number of the lowest-numbered pending object routed to that line. Object number n (1..64) is pending bit n-1. A routing bit of 0 selects line 0 and a routing bit of 1 selects line 1.
- R4: Each line output is high exactly when its line enable is set and its identifier is nonzero; clearing the enable drops the line in the same cycle.
- R5: Reading the error/status register clears the wake-up, Rx-OK, Tx-OK, parity and last-error-code fields and the combined pending state, from the next cycle on. During the read cycle the value returned still shows the fields. The read value layout is [2:0] last-error code, [3] Tx-OK, [4] Rx-OK, [5] warning level, [6] bus-off, [7] wake-up, [8] parity.
- R6: A write strobe to the error/status register neither creates nor clears any interrupt and leaves the register unchanged.
- R7: A core status update sets the combined source only when the status-group enable is set. A change of the bus-off or warning level, or a parity pulse, sets it only when the error-group enable is set. The status fields are recorded regardless of these enables. Line 1's identifier never takes the value 0x8000.
- R8: Identifiers keep following the pending sources while both line enables are cleared.
- R9: When the pending flag of the object currently identified is cleared, the identifier moves to the next pending object on that line in the same cycle, or to 0 if there is none.
- R10: An enabled event arriving in the same cycle as a read wins: the combined source stays pending and the new status fields are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| obj_pend | input | 64 | Pending flag per message object (bit n-1 = object n) |
| obj_route | input | 64 | Line select per object, 0 = line 0, 1 = line 1 |
| st_upd | input | 1 | Core updated the status fields this cycle |
| st_wake | input | 1 | Wake-up flag delivered with the update |
| st_rxok | input | 1 | Rx-OK flag delivered with the update |
| st_txok | input | 1 | Tx-OK flag delivered with the update |
| st_lec | input | 3 | Last-error code delivered with the update |
| err_boff | input | 1 | Bus-off level from the core |
| err_ewarn | input | 1 | Error-warning level from the core |
| err_parity | input | 1 | Parity-error pulse |
| line0_en | input | 1 | Enable for line 0 |
| line1_en | input | 1 | Enable for line 1 |
| status_grp_en | input | 1 | Enable for status-change interrupts |
| error_grp_en | input | 1 | Enable for error interrupts |
| es_read | input | 1 | Read strobe of the error/status register |
| es_wr | input | 1 | Write strobe of the error/status register |
| es_rdata | output | 9 | Error/status register read value |
| irq_line0 | output | 1 | Interrupt line 0 |
| irq_line1 | output | 1 | Interrupt line 1 |
| ident0 | output | 16 | Identifier of line 0 |
| ident1 | output | 16 | Identifier of line 1 |

## Verification
The only internal state is the combined-source state machine and the error/status fields. If the state machine is stuck, `ident0` shows 0x8000 where an object number is expected, or the reverse, one cycle after the update or read that should have moved it. A wrong field update appears in `es_rdata` in the cycle after the event. A faulty priority encode or mask is visible in the same cycle as the pending-vector change. The bench therefore samples each identifier both in the cycle of an input change and in the cycle after it.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    typedef enum logic {
        SE_IDLE = 1'b0,
        SE_PEND = 1'b1
    } se_state_t;

    localparam int IDENT_W    = 16;
    localparam int ES_W       = 9;
    localparam logic [IDENT_W-1:0] SE_CODE = 16'h8000;

    typedef struct packed {
        logic       parity;
        logic       wake;
        logic       boff;
        logic       ewarn;
        logic       rxok;
        logic       txok;
        logic [2:0] lec;
    } es_reg_t;

endpackage

// File: rtl/can_irq_prio_enc.sv
module can_irq_prio_enc #(
    parameter int N_REQ = 64,
    parameter int OUT_W = 16
) (
    input  logic [N_REQ-1:0] req,
    output logic [OUT_W-1:0] code
);
    // lowest index wins; code is index + 1, zero when idle
    always_comb begin
        code = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) code = OUT_W'(i + 1);
        end
    end

    always_comb begin
        if (code != '0) begin
            assert_code_points_at_req_R3: assert (req[code - 1'b1])
                else $error("encoder code does not point at a request");
        end
    end
endmodule

// File: rtl/can_irq_es_ctrl.sv
module can_irq_es_ctrl
    import can_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_upd,
    input  logic            st_wake,
    input  logic            st_rxok,
    input  logic            st_txok,
    input  logic [2:0]      st_lec,
    input  logic            err_boff,
    input  logic            err_ewarn,
    input  logic            err_parity,
    input  logic            status_grp_en,
    input  logic            error_grp_en,
    input  logic            es_read,
    input  logic            es_wr,
    output logic [ES_W-1:0] es_rdata,
    output logic            se_pend
);
    se_state_t state_q, state_d;
    es_reg_t   es_q, es_d;
    logic      err_evt, set_evt;

    assign err_evt = (err_boff != es_q.boff) || (err_ewarn != es_q.ewarn) || err_parity;
    assign set_evt = (st_upd && status_grp_en) || (err_evt && error_grp_en);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SE_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SE_IDLE: if (set_evt)                state_d = SE_PEND;
            SE_PEND: if (es_read && !set_evt)    state_d = SE_IDLE;
            default:                             state_d = SE_IDLE;
        endcase
    end

    // register contents; write strobe deliberately not a term here
    always_comb begin
        es_d       = es_q;
        es_d.boff  = err_boff;
        es_d.ewarn = err_ewarn;
        if (es_read) begin
            es_d.wake   = 1'b0;
            es_d.rxok   = 1'b0;
            es_d.txok   = 1'b0;
            es_d.lec    = 3'd0;
            es_d.parity = 1'b0;
        end
        if (err_parity) es_d.parity = 1'b1;
        if (st_upd) begin
            es_d.wake = st_wake | (es_read ? 1'b0 : es_q.wake);
            es_d.rxok = st_rxok | (es_read ? 1'b0 : es_q.rxok);
            es_d.txok = st_txok | (es_read ? 1'b0 : es_q.txok);
            es_d.lec  = st_lec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

    // outputs
    always_comb begin
        es_rdata = es_q;
        se_pend  = (state_q == SE_PEND);
    end

    assert_enabled_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_upd && status_grp_en) |=> se_pend);
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (es_read && !set_evt) |=> (!se_pend && es_rdata[4:0] == 5'd0));
    assert_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (es_wr && !es_read && !set_evt) |=> $stable(se_pend));
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (es_read && set_evt) |=> se_pend);
endmodule

// File: rtl/can_irq_ident.sv
module can_irq_ident
    import can_irq_pkg::*;
#(
    parameter int NUM_OBJ = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_OBJ-1:0]  obj_pend,
    input  logic [NUM_OBJ-1:0]  obj_route,
    input  logic                st_upd,
    input  logic                st_wake,
    input  logic                st_rxok,
    input  logic                st_txok,
    input  logic [2:0]          st_lec,
    input  logic                err_boff,
    input  logic                err_ewarn,
    input  logic                err_parity,
    input  logic                line0_en,
    input  logic                line1_en,
    input  logic                status_grp_en,
    input  logic                error_grp_en,
    input  logic                es_read,
    input  logic                es_wr,
    output logic [ES_W-1:0]     es_rdata,
    output logic                irq_line0,
    output logic                irq_line1,
    output logic [IDENT_W-1:0]  ident0,
    output logic [IDENT_W-1:0]  ident1
);
    localparam int N_LINES = 2;

    logic               se_pend;
    logic [IDENT_W-1:0] obj_code [N_LINES];

    can_irq_es_ctrl u_es (
        .clk           (clk),
        .rst_n         (rst_n),
        .st_upd        (st_upd),
        .st_wake       (st_wake),
        .st_rxok       (st_rxok),
        .st_txok       (st_txok),
        .st_lec        (st_lec),
        .err_boff      (err_boff),
        .err_ewarn     (err_ewarn),
        .err_parity    (err_parity),
        .status_grp_en (status_grp_en),
        .error_grp_en  (error_grp_en),
        .es_read       (es_read),
        .es_wr         (es_wr),
        .es_rdata      (es_rdata),
        .se_pend       (se_pend)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [NUM_OBJ-1:0] routed;
        assign routed = (g == 0) ? (obj_pend & ~obj_route) : (obj_pend & obj_route);
        can_irq_prio_enc #(.N_REQ(NUM_OBJ), .OUT_W(IDENT_W)) u_enc (
            .req  (routed),
            .code (obj_code[g])
        );
    end

    always_comb begin
        ident0    = se_pend ? SE_CODE : obj_code[0];
        ident1    = obj_code[1];
        irq_line0 = line0_en && (ident0 != '0);
        irq_line1 = line1_en && (ident1 != '0);
    end

    assert_line1_never_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ident1 != SE_CODE);
    assert_status_outranks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        se_pend |-> (ident0 == SE_CODE));
    assert_line0_routing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ident0 != '0 && ident0 != SE_CODE) |-> !obj_route[ident0 - 1'b1]);
    assert_line1_routing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ident1 != '0) |-> obj_route[ident1 - 1'b1]);
endmodule

// File: tb/test_can_irq_ident.sv
module test_can_irq_ident;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] obj_pend = '0, obj_route = '0;
    logic        st_upd = 0, st_wake = 0, st_rxok = 0, st_txok = 0;
    logic [2:0]  st_lec = 0;
    logic        err_boff = 0, err_ewarn = 0, err_parity = 0;
    logic        line0_en = 0, line1_en = 0, status_grp_en = 0, error_grp_en = 0;
    logic        es_read = 0, es_wr = 0;
    logic [8:0]  es_rdata;
    logic        irq_line0, irq_line1;
    logic [15:0] ident0, ident1;

    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    can_irq_ident i_can_irq_ident (.*);

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ident0 reset", ident0, 16'h0);
        chk("R1 ident1 reset", ident1, 16'h0);
        chk("R1 lines reset", {14'd0, irq_line1, irq_line0}, 16'h0);
        chk("R1 rdata reset", {7'd0, es_rdata}, 16'h0);
    endtask

    task automatic t_objects();
        line0_en = 1; line1_en = 1;
        obj_pend = (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 3) | (64'd1 << 40);
        obj_route = (64'd1 << 3) | (64'd1 << 40);
        #1;
        chk("R3 ident0 lowest on line0", ident0, 16'd6);
        chk("R3 ident1 lowest on line1", ident1, 16'd4);
        chk("R4 both lines high", {14'd0, irq_line1, irq_line0}, 16'h3);
        obj_pend[5] = 0; obj_pend[3] = 0;
        #1;
        chk("R9 ident0 next object", ident0, 16'd10);
        chk("R9 ident1 next object", ident1, 16'd41);
        line1_en = 0; #1;
        chk("R4 line1 drops on disable", {15'd0, irq_line1}, 16'h0);
        obj_pend = '0; #1;
        chk("R1 ident0 idle", ident0, 16'd0);
        chk("R1 line0 low idle", {15'd0, irq_line0}, 16'h0);
        tick();
    endtask

    task automatic t_disabled_tracking();
        line0_en = 0; line1_en = 0;
        obj_pend = (64'd1 << 63) | (64'd1 << 62); obj_route = (64'd1 << 62);
        #1;
        chk("R8 ident0 tracks while disabled", ident0, 16'd64);
        chk("R8 ident1 tracks while disabled", ident1, 16'd63);
        chk("R4 lines low while disabled", {14'd0, irq_line1, irq_line0}, 16'h0);
        obj_pend = '0; obj_route = '0;
        tick();
    endtask

    task automatic t_status();
        line0_en = 1; line1_en = 1; status_grp_en = 1;
        obj_pend = 64'd1 << 2; obj_route = '0;
        st_upd = 1; st_rxok = 1; st_lec = 3'd3;
        tick();
        st_upd = 0; st_rxok = 0; st_lec = 0;
        chk("R2 status code outranks objects", ident0, 16'h8000);
        chk("R4 line0 high on status", {15'd0, irq_line0}, 16'h1);
        chk("R7 line1 unaffected", ident1, 16'h0);
        chk("R5 fields recorded", {7'd0, es_rdata}, 16'h013);
        es_wr = 1;
        tick();
        es_wr = 0;
        chk("R6 write leaves ident", ident0, 16'h8000);
        chk("R6 write leaves register", {7'd0, es_rdata}, 16'h013);
        line0_en = 0; #1;
        chk("R4 line0 drops with status pending", {15'd0, irq_line0}, 16'h0);
        line0_en = 1;
        es_read = 1; #1;
        chk("R5 read returns fields", {7'd0, es_rdata}, 16'h013);
        tick();
        es_read = 0;
        chk("R5 read clears status code", ident0, 16'd3);
        chk("R5 read clears fields", {7'd0, es_rdata}, 16'h000);
        obj_pend = '0;
        tick();
    endtask

    task automatic t_groups();
        status_grp_en = 0; error_grp_en = 0;
        st_upd = 1; st_txok = 1;
        tick();
        st_upd = 0; st_txok = 0;
        chk("R7 status disabled no code", ident0, 16'h0);
        chk("R7 fields still recorded", {7'd0, es_rdata}, 16'h008);
        err_boff = 1;
        tick();
        chk("R7 error disabled no code", ident0, 16'h0);
        error_grp_en = 1; err_boff = 0; err_ewarn = 1;
        tick();
        chk("R7 error change sets code", ident0, 16'h8000);
        chk("R7 never on line1", ident1, 16'h0);
        es_read = 1;
        tick();
        es_read = 0;
        chk("R5 read clears error code", ident0, 16'h0);
        chk("R5 levels kept after read", {7'd0, es_rdata}, 16'h020);
        err_parity = 1;
        tick();
        err_parity = 0;
        chk("R7 parity sets code", ident0, 16'h8000);
        chk("R7 parity field", {7'd0, es_rdata}, 16'h120);
        status_grp_en = 1; es_read = 1; st_upd = 1; st_wake = 1;
        tick();
        es_read = 0; st_upd = 0; st_wake = 0;
        chk("R10 event beats read", ident0, 16'h8000);
        chk("R10 new fields kept", {7'd0, es_rdata}, 16'h0A0);
        es_read = 1;
        tick();
        es_read = 0;
        chk("R5 final clear", ident0, 16'h0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_objects();
        t_disabled_tracking();
        t_status();
        t_groups();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule